// File: doc/BRIEF.md
# Audio Input Sample FIFO Front End

This block is the host-facing write side of an audio sample rate converter. Software writes 32-bit stereo sample words through a write-only data port. Each word can have its byte order reversed on the way in, and is then stored in a small first-in first-out buffer. The converter core drains the buffer through a valid/ready handshake. Reads of the data port always return zero.

The block keeps an occupancy count and raises a low-water request flag whenever that count has fallen to or below a programmable threshold. Four thresholds are available through a 2-bit code. Software may clear the flag. A separate enable gates the flag onto the interrupt line. A single-cycle clear command empties the buffer. Out of reset the flag is already raised, because the empty buffer is below every threshold.

Top module: `smp_infifo_front`

## Requirements
- R1: Words popped through `core_data` come out in the order they were accepted. `core_valid` is high exactly when at least one word is stored.
- R2: `dport_rdata` is 0 at all times.
- R3: `level` equals the number of stored words (0 to DEPTH). It changes on the clock edge that accepts a push or a pop.
- R4: A write while `level` equals DEPTH is dropped, even if a pop happens in the same cycle. Stored words and their order are left intact.
- R5: A pop happens on every edge where `core_valid` and `core_ready` are both high, and it removes the head word.
- R6: With `cfg_swap`=1 at the write, the stored word is `wr_data` with its bytes reversed (bits 7:0 go to 31:24, 15:8 go to 23:16, and so on). With `cfg_swap`=0 the word is stored unchanged.
- R7: `cfg_trig` selects the threshold: 0 gives 0, 1 gives 2, 2 gives 4 and 3 gives 6. On any edge where the level held before that edge is at or below the threshold, and no software clear is applied, `low_flag` becomes 1.
- R8: `flag_wr` with `flag_wdata`=0 clears `low_flag` on that edge, and this takes priority over setting it. `flag_wr` with `flag_wdata`=1 has no effect. If the condition still holds, the flag sets again on the following edge.
- R9: `low_irq` is `low_flag` AND `cfg_irq_en`. The flag keeps recording while the interrupt is disabled.
- R10: `clr` empties the buffer on its edge. It overrides a push and a pop in the same cycle.
- R11: After reset `level` is 0, `core_valid` is 0 and `low_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the data port |
| wr_data | input | WORD_W (32) | Host write data |
| dport_rdata | output | WORD_W (32) | Readback of the data port, always zero |
| cfg_swap | input | 1 | 1 reverses the byte order of the written word |
| cfg_trig | input | 2 | Low-water threshold code |
| cfg_irq_en | input | 1 | Interrupt enable for the low-water flag |
| flag_wr | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Value written to the flag (0 clears it, 1 is ignored) |
| clr | input | 1 | Empties the buffer |
| core_valid | output | 1 | Head word available to the core |
| core_ready | input | 1 | Core accepts the head word |
| core_data | output | WORD_W (32) | Head word |
| level | output | LVL_W (4) | Number of stored words |
| low_flag | output | 1 | Low-water request flag |
| low_irq | output | 1 | Gated low-water interrupt |

## Verification
The bench builds the block with its defaults: DEPTH 8, WORD_W 32, LVL_W 4. With 8 entries, the highest threshold of 6 still leaves levels 7 and 8 above every threshold. As a result, each of the four codes sees the flag held low, the flag set, the buffer full with writes dropped, and the buffer empty. The 4-byte word makes the byte reversal visible on distinct byte values. The random bursts alternate between write-heavy and read-heavy phases so that the level sweeps the whole range under every code.

// File: rtl/smpf_pkg.sv
// Shared definitions for the input sample FIFO front end.
// Assumes thresholds are even values coded by a 2-bit field.
package smpf_pkg;
    localparam int TRIG_CODE_W = 2;
    localparam int THR_W       = 3;

    // Threshold in entries for a trigger code (0, 2, 4, 6).
    function automatic logic [THR_W-1:0] trig_level(input logic [TRIG_CODE_W-1:0] code);
        return {code, 1'b0};
    endfunction
endpackage

// File: rtl/smpf_byte_order.sv
// Optional byte-order reversal of a data word.
// Assumes W is a whole number of bytes.
module smpf_byte_order #(
    parameter int W = 32
) (
    input  logic         swap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    // One multiplexer per byte lane: straight or mirrored source.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign dout[8*i +: 8] = swap ? din[8*(NB-1-i) +: 8] : din[8*i +: 8];
    end
endmodule

// File: rtl/smpf_store.sv
// Circular word buffer with occupancy count.
// Assumes DEPTH >= 2. A push while full is dropped. clr overrides both sides.
module smpf_store #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             clr,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rd_ptr];

    // Storage array: written only on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers and count: reset and clear both return to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/smpf_lowwater.sv
// Low-water request flag and gated interrupt.
// Assumes LVL_W >= 3 so every threshold fits the count width.
module smpf_lowwater #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] count,
    input  logic [1:0]       trig_code,
    input  logic             sw_wr,
    input  logic             sw_wdata,
    input  logic             irq_en,
    output logic             flag,
    output logic             irq
);
    logic [smpf_pkg::THR_W-1:0] thr;
    logic                       below;

    assign thr   = smpf_pkg::trig_level(trig_code);
    assign below = (count <= LVL_W'(thr));
    assign irq   = flag && irq_en;

    // Flag register: set at reset, a software zero wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b1;
        else if (sw_wr && !sw_wdata) flag <= 1'b0;
        else if (below)            flag <= 1'b1;
    end
endmodule

// File: rtl/smp_infifo_front.sv
// Input side of a sample rate converter: host write port with byte
// reversal, word buffer towards the core, and low-water request.
// Assumes DEPTH >= 7 so that all four thresholds lie below full.
module smp_infifo_front #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] dport_rdata,
    input  logic              cfg_swap,
    input  logic [1:0]        cfg_trig,
    input  logic              cfg_irq_en,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    input  logic              clr,
    output logic              core_valid,
    input  logic              core_ready,
    output logic [WORD_W-1:0] core_data,
    output logic [LVL_W-1:0]  level,
    output logic              low_flag,
    output logic              low_irq
);
    logic [WORD_W-1:0] swapped;
    logic              full, empty;

    assign dport_rdata = '0;
    assign core_valid  = !empty;

    smpf_byte_order #(.W(WORD_W)) u_order (
        .swap (cfg_swap),
        .din  (wr_data),
        .dout (swapped)
    );

    smpf_store #(.W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (swapped),
        .pop       (core_ready),
        .clr       (clr),
        .head      (core_data),
        .count     (level),
        .full      (full),
        .empty     (empty)
    );

    smpf_lowwater #(.LVL_W(LVL_W)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (level),
        .trig_code (cfg_trig),
        .sw_wr     (flag_wr),
        .sw_wdata  (flag_wdata),
        .irq_en    (cfg_irq_en),
        .flag      (low_flag),
        .irq       (low_irq)
    );

    // full only feeds the store's own push gate, it is not a port
    logic unused_full;
    assign unused_full = full;
endmodule

// File: rtl/smp_infifo_front_chk.sv
// Property checker for smp_infifo_front, attached by bind.
module smp_infifo_front_chk #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       cfg_trig,
    input logic             cfg_irq_en,
    input logic             flag_wr,
    input logic             flag_wdata,
    input logic             clr,
    input logic             core_valid,
    input logic             core_ready,
    input logic [LVL_W-1:0] level,
    input logic             low_flag,
    input logic             low_irq
);
    int thr;
    assign thr = 2 * int'(cfg_trig);

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(level) == DEPTH && !core_ready && !clr) |=> int'(level) == DEPTH);

    a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && core_ready && !wr_en && !clr) |=> level == $past(level) - 1'b1);

    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!(flag_wr && !flag_wdata) && int'(level) <= thr) |=> low_flag);

    a_r8_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata) |=> !low_flag);

    a_r8_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata && !low_flag && int'(level) > thr) |=> !low_flag);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !low_irq);

    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0 && !core_valid));

    a_r11_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (level == '0 && low_flag));
endmodule

bind smp_infifo_front smp_infifo_front_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .cfg_trig   (cfg_trig),
    .cfg_irq_en (cfg_irq_en),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .clr        (clr),
    .core_valid (core_valid),
    .core_ready (core_ready),
    .level      (level),
    .low_flag   (low_flag),
    .low_irq    (low_irq)
);

// File: tb/test_smp_infifo_front.sv
`timescale 1ns/100ps
module test_smp_infifo_front;
    localparam int W = 32;
    localparam int DEPTH = 8;
    localparam int LVL_W = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0, cfg_swap = 0, cfg_irq_en = 0, flag_wr = 0, flag_wdata = 0;
    logic clr = 0, core_ready = 0;
    logic [1:0] cfg_trig = 0;
    logic [W-1:0] wr_data = 0;
    logic [W-1:0] dport_rdata, core_data;
    logic core_valid, low_flag, low_irq;
    logic [LVL_W-1:0] level;

    int checks = 0, fails = 0, cycles = 0;
    logic [W-1:0] q[$];
    logic mflag = 1;
    bit done = 0;

    always #2.5 clk = ~clk;

    smp_infifo_front i_smp_infifo_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dport_rdata(dport_rdata), .cfg_swap(cfg_swap), .cfg_trig(cfg_trig),
        .cfg_irq_en(cfg_irq_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .clr(clr), .core_valid(core_valid), .core_ready(core_ready),
        .core_data(core_data), .level(level), .low_flag(low_flag), .low_irq(low_irq)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] rev(input logic [W-1:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // Reference model: updated on each edge, compared 1 ns later.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            mflag = 1;
        end else begin
            bit was_full;
            bit popping;
            was_full = (q.size() == DEPTH);
            popping  = (q.size() > 0) && core_ready;
            if (flag_wr && !flag_wdata) mflag = 0;
            else if (q.size() <= 2 * int'(cfg_trig)) mflag = 1;
            if (clr) q.delete();
            else begin
                if (popping) void'(q.pop_front());
                if (wr_en && !was_full) q.push_back(cfg_swap ? rev(wr_data) : wr_data);
            end
        end
        #1;
        if (rst_n) begin
            chk("R3 level", W'(level), W'(q.size()));
            chk("R1 valid", W'(core_valid), W'(q.size() > 0));
            if (q.size() > 0) chk("R1/R6 head data", core_data, q[0]);
            chk("R7 flag", W'(low_flag), W'(mflag));
            chk("R9 irq", W'(low_irq), W'(mflag & cfg_irq_en));
            chk("R2 readback", dport_rdata, '0);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        wr_en = 0; flag_wr = 0; clr = 0; core_ready = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11 reset state
        chk("R11 level", W'(level), 0);
        chk("R11 valid", W'(core_valid), 0);
        chk("R11 flag", W'(low_flag), 1);
        chk("R2 readback", dport_rdata, '0);

        // R6 byte reversal
        wr_en = 1; cfg_swap = 1; wr_data = 32'h11223344;
        tick();
        chk("R6 swapped head", core_data, 32'h44332211);
        cfg_swap = 0; wr_data = 32'hA1B2C3D4;
        tick();
        chk("R6 straight count", W'(level), 2);
        wr_en = 0; core_ready = 1;
        tick();
        chk("R6 straight word", core_data, 32'hA1B2C3D4);
        tick();
        chk("R5 drained", W'(core_valid), 0);

        // R4 full drop
        core_ready = 0; wr_en = 1;
        for (int i = 0; i < 10; i++) begin
            wr_data = 32'hC0DE0000 + i;
            tick();
        end
        wr_en = 0;
        chk("R4 full level", W'(level), DEPTH);
        chk("R4 head intact", core_data, 32'hC0DE0000);

        // R8 software clear and ignored one, threshold 6
        cfg_trig = 2'd3;
        flag_wr = 1; flag_wdata = 0;
        tick();
        chk("R8 cleared", W'(low_flag), 0);
        flag_wdata = 1;
        tick();
        chk("R8 one ignored", W'(low_flag), 0);
        flag_wr = 0; core_ready = 1;
        tick();
        tick();
        core_ready = 0;
        chk("R5 level after pops", W'(level), 6);
        chk("R7 flag lags level", W'(low_flag), 0);
        tick();
        chk("R7 flag set at 6", W'(low_flag), 1);
        flag_wr = 1; flag_wdata = 0;
        tick();
        flag_wr = 0;
        chk("R8 clear while below", W'(low_flag), 0);
        tick();
        chk("R8 sets again", W'(low_flag), 1);

        // R9 interrupt gating
        cfg_irq_en = 0;
        #0.5;
        chk("R9 masked irq", W'(low_irq), 0);
        chk("R9 flag kept", W'(low_flag), 1);
        cfg_irq_en = 1;
        #0.5;
        chk("R9 enabled irq", W'(low_irq), 1);

        // R10 clear overrides push and pop
        clr = 1; wr_en = 1; core_ready = 1; wr_data = 32'h0BADF00D;
        tick();
        idle();
        chk("R10 level", W'(level), 0);
        chk("R10 valid", W'(core_valid), 0);

        // Random bursts under every trigger code (R7 per code)
        for (int code = 0; code < 4; code++) begin
            cfg_trig = 2'(code);
            for (int n = 0; n < 600; n++) begin
                int pw;
                pw = (n % 150 < 75) ? 75 : 25;
                wr_en      = ($urandom_range(99) < pw);
                core_ready = ($urandom_range(99) < 100 - pw);
                wr_data    = $urandom;
                cfg_swap   = $urandom_range(1);
                flag_wr    = ($urandom_range(99) < 8);
                flag_wdata = $urandom_range(1);
                clr        = ($urandom_range(199) == 0);
                if (n % 40 == 0) cfg_irq_en = $urandom_range(1);
                tick();
            end
            idle();
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule